// File: doc/BRIEF.md
# Masked Time Alarm and Interrupt Pin Controller

This block sits beside a calendar clock. On every once-per-second update strobe it compares the current BCD seconds, minutes, hours and date values against four alarm registers. Each alarm register carries an ignore bit, so the alarm can be set to fire every second, once a minute, hourly, daily, or at one exact date and time. A match sets the alarm flag. A watchdog timeout and a power-fail event set their own flags in the same flags register. Reading that register over the bus clears all three flags.

Each flag has an enable bit. When an enabled source is flagged, the block drives a single interrupt pin, which is modelled as a drive-enable together with a driven value. The pin can be push-pull active high or open-drain active low. It can either follow the flags as a level or emit a one-shot pulse of fixed length, and a flags read cuts such a pulse short. While the system runs from backup power, only the alarm source can raise the pin. This requires a dedicated backup-alarm enable and the open-drain active-low setting.

Register map on the 3-bit bus address: 0 flags (bit0 watchdog, bit1 alarm, bit2 power fail, read clears), 1 control, 2 seconds alarm, 3 minutes alarm, 4 hours alarm, 5 date alarm. Every other address reads as zero.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x14 (power-fail enable and pulse mode, open-drain active low), the flags read 0, the four alarm registers read 0x00, and the pin is not driven.
- R2: In an alarm register, bit7 = 1 removes that field from the compare and bit7 = 0 requires bits 6:0 to equal the current field value. With all four ignore bits set, every strobe is a match.
- R3: The alarm flag (flags bit1) is set only on a clock where the second strobe is high and every compared field matches. A matching time without the strobe sets nothing.
- R4: A watchdog timeout pulse sets flags bit0 and a power-fail pulse sets flags bit2, whatever the enables are.
- R5: A bus read of address 0 (select high, write low) returns the flags and clears all of them at that clock edge. A bus write to address 0 changes nothing.
- R6: A flag event that arrives on the same clock as a flags read is kept. The read itself returns the old value.
- R7: In level mode (control bit4 = 0) the pin is active while any flag is set whose enable is set. The enables are control bit0 watchdog, bit1 alarm and bit2 power fail.
- R8: In pulse mode (control bit4 = 1), an enabled event makes the pin active for exactly PULSE_CYC clocks, starting with the edge that captures the event. An event that arrives during the pulse does not lengthen it.
- R9: A flags read ends an active pulse at that clock edge.
- R10: With control bit5 = 1 the pin is always driven and its value equals the active state. With bit5 = 0 the pin is driven low only while active and is released otherwise.
- R11: While the backup input is high, the watchdog and power-fail sources cannot raise the pin. The alarm source can raise it only when control bit3 and bit1 are set and bit5 is 0. With bit5 = 1 the pin is released.
- R12: Control bits 5:0 and all eight bits of each alarm register are written at addresses 1 to 5 and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-clock strobe when the time advances |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD |
| now_date | input | 7 | Current day of month, BCD |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| pwr_fail | input | 1 | Power-fail event pulse |
| on_backup | input | 1 | High while running from backup supply |
| bus_sel | input | 1 | Register access this clock |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq_drv_en | output | 1 | Interrupt pin driver enable |
| irq_val | output | 1 | Value driven on the interrupt pin |

## Verification
The bench builds the block with PULSE_CYC = 6. This allows a full pulse, its end, an extra event in its third clock and an early cut by a flags read to be observed within a few dozen clocks, and every one of them to be compared against the reference model on each edge. The alarm paths use small BCD values that switch one field at a time between ignored and compared.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int FIELD_W    = 7;
  localparam int NUM_FIELDS = 4;
  localparam int NUM_SRC    = 3;

  typedef enum logic [2:0] {
    A_FLAGS = 3'd0,
    A_CTRL  = 3'd1,
    A_SEC   = 3'd2,
    A_MIN   = 3'd3,
    A_HOUR  = 3'd4,
    A_DATE  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic act_high;
    logic pulse_mode;
    logic bkup_alm_en;
    logic pf_en;
    logic alm_en;
    logic wdog_en;
  } irq_ctrl_t;

  localparam logic [5:0] CTRL_RST = 6'h14;

  // one alarm field: ignore bit in the top position, else exact compare
  function automatic logic field_hit(input logic [FIELD_W:0] alm,
                                     input logic [FIELD_W-1:0] now);
    return alm[FIELD_W] | (alm[FIELD_W-1:0] == now);
  endfunction

  // effective per-source enables {pf, alarm, wdog} given supply state
  function automatic logic [NUM_SRC-1:0] src_enables(input irq_ctrl_t c,
                                                     input logic backup);
    logic alm_ok;
    alm_ok = c.alm_en & (~backup | (c.bkup_alm_en & ~c.act_high));
    return {c.pf_en & ~backup, alm_ok, c.wdog_en & ~backup};
  endfunction
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W
) (
  input  logic [NF-1:0][FW:0]   alm,
  input  logic [NF-1:0][FW-1:0] now,
  input  logic                  tick,
  output logic                  hit
);
  logic [NF-1:0] field_ok;

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign field_ok[i] = field_hit(alm[i], now[i]);
  end

  assign hit = tick & (&field_ok);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int NS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set,
  input  logic          clr,
  output logic [NS-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | set;
  end
endmodule

// File: rtl/rtc_irq_pin.sv
module rtc_irq_pin #(
  parameter int PULSE_CYC = 16,
  localparam int CNT_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clr,
  input  logic             level_req,
  input  logic             pulse_mode,
  input  logic             act_high,
  input  logic             backup,
  output logic [CNT_W-1:0] pulse_cnt,
  output logic             drv_en,
  output logic             val
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pulse_cnt <= '0;
    else if (start && pulse_cnt == '0)   pulse_cnt <= LOAD;
    else if (clr)                        pulse_cnt <= '0;
    else if (pulse_cnt != '0)            pulse_cnt <= pulse_cnt - 1'b1;
  end

  assign active = pulse_mode ? (pulse_cnt != '0) : level_req;

  always_comb begin
    if (act_high) begin
      drv_en = ~backup;
      val    = ~backup & active;
    end else begin
      drv_en = active;
      val    = 1'b0;
    end
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int PULSE_CYC = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [6:0] now_sec,
  input  logic [6:0] now_min,
  input  logic [6:0] now_hour,
  input  logic [6:0] now_date,
  input  logic       wdt_expire,
  input  logic       pwr_fail,
  input  logic       on_backup,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_drv_en,
  output logic       irq_val
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  irq_ctrl_t                         ctrl_q;
  logic [NUM_FIELDS-1:0][FIELD_W:0]  alm_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_vec;
  logic                              alarm_hit;
  logic                              flags_rd;
  logic [NUM_SRC-1:0]                src_evt;
  logic [NUM_SRC-1:0]                flags_q;
  logic [NUM_SRC-1:0]                en_eff;
  logic                              pulse_start;
  logic                              level_req;
  logic [CNT_W-1:0]                  pulse_cnt;

  assign now_vec = {now_date, now_hour, now_min, now_sec};

  // register writes; field index i lives at address A_SEC + i
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= irq_ctrl_t'(CTRL_RST);
      alm_q  <= '0;
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_q <= irq_ctrl_t'(bus_wdata[5:0]);
      for (int i = 0; i < NUM_FIELDS; i++)
        if (bus_addr == 3'(A_SEC + i)) alm_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_FLAGS) bus_rdata = {5'b0, flags_q};
    if (bus_addr == A_CTRL)  bus_rdata = {2'b0, ctrl_q};
    for (int i = 0; i < NUM_FIELDS; i++)
      if (bus_addr == 3'(A_SEC + i)) bus_rdata = alm_q[i];
  end

  rtc_alarm_cmp #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_cmp (
    .alm  (alm_q),
    .now  (now_vec),
    .tick (sec_tick),
    .hit  (alarm_hit)
  );

  assign flags_rd = bus_sel & ~bus_wr & (bus_addr == A_FLAGS);
  assign src_evt  = {pwr_fail, alarm_hit, wdt_expire};

  rtc_irq_flags #(.NS(NUM_SRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (src_evt),
    .clr   (flags_rd),
    .flags (flags_q)
  );

  assign en_eff      = src_enables(ctrl_q, on_backup);
  assign pulse_start = |(src_evt & en_eff);
  assign level_req   = |(flags_q & en_eff);

  rtc_irq_pin #(.PULSE_CYC(PULSE_CYC)) u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (pulse_start),
    .clr        (flags_rd),
    .level_req  (level_req),
    .pulse_mode (ctrl_q.pulse_mode),
    .act_high   (ctrl_q.act_high),
    .backup     (on_backup),
    .pulse_cnt  (pulse_cnt),
    .drv_en     (irq_drv_en),
    .val        (irq_val)
  );
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int PULSE_CYC = 16,
  localparam int CNT_W    = $clog2(PULSE_CYC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             wdt_expire,
  input logic             pwr_fail,
  input logic             on_backup,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic             irq_drv_en,
  input logic             irq_val,
  input logic             alarm_hit,
  input logic             flags_rd,
  input logic [2:0]       flags_q,
  input logic             act_high,
  input logic [CNT_W-1:0] pulse_cnt
);
  AST_NO_TICK_NO_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |-> !alarm_hit); // R3

  AST_ALARM_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> flags_q[1]); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !alarm_hit && !wdt_expire && !pwr_fail) |=> flags_q == 3'b000); // R5

  AST_FLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd0 && !alarm_hit && !wdt_expire && !pwr_fail)
      |=> $stable(flags_q)); // R5

  AST_PULSE_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt != '0 && !flags_rd) |=> pulse_cnt == CNT_W'($past(pulse_cnt) - 1'b1)); // R8

  AST_READ_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && pulse_cnt != '0) |=> pulse_cnt == '0); // R9

  AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !act_high |-> !irq_val); // R10

  AST_BACKUP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_backup && act_high) |-> !irq_drv_en); // R11
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .wdt_expire (wdt_expire),
  .pwr_fail   (pwr_fail),
  .on_backup  (on_backup),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .irq_drv_en (irq_drv_en),
  .irq_val    (irq_val),
  .alarm_hit  (alarm_hit),
  .flags_rd   (flags_rd),
  .flags_q    (flags_q),
  .act_high   (ctrl_q.act_high),
  .pulse_cnt  (pulse_cnt)
);

// File: tb/rtc_irq_ctrl_tb.sv
module rtc_irq_ctrl_tb;
  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 0, wdt_expire = 0, pwr_fail = 0, on_backup = 0;
  logic [6:0] now_sec = 0, now_min = 0, now_hour = 0, now_date = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq_drv_en, irq_val;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rtc_irq_ctrl #(.PULSE_CYC(P)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_ctrl, m_flags, m_left;
  int m_alm[4];

  function automatic int eff_of(int c, bit bk);
    int e = 0;
    if (!bk && (c & 1)) e += 1;
    if (!bk && (c & 4)) e += 4;
    if ((c & 2) != 0) begin
      if (!bk) e += 2;
      else if ((c & 8) != 0 && (c & 32) == 0) e += 2;
    end
    return e;
  endfunction

  always @(posedge clk) begin
    bit rd, hit, start, act, bk;
    int now[4];
    int e, exp_en, exp_val, exp_rd, evts;
    now = '{int'(now_sec), int'(now_min), int'(now_hour), int'(now_date)};
    bk = on_backup;
    if (!rst_n) begin
      m_ctrl = 'h14; m_flags = 0; m_left = 0; m_alm = '{0, 0, 0, 0};
    end else begin
      rd  = bus_sel && !bus_wr && bus_addr == 0;
      hit = sec_tick;
      foreach (m_alm[i]) if (m_alm[i] < 128 && m_alm[i] != now[i]) hit = 0;
      evts = (wdt_expire ? 1 : 0) + (hit ? 2 : 0) + (pwr_fail ? 4 : 0);
      e = eff_of(m_ctrl, bk);
      start = (evts & e) != 0;
      if (start && m_left == 0) m_left = P;
      else if (rd) m_left = 0;
      else if (m_left > 0) m_left--;
      if (rd) m_flags = 0;
      m_flags |= evts;
      if (bus_sel && bus_wr) begin
        if (bus_addr == 1) m_ctrl = bus_wdata & 'h3f;
        if (bus_addr >= 2 && bus_addr <= 5) m_alm[bus_addr - 2] = bus_wdata;
      end
    end
    #4;
    e = eff_of(m_ctrl, bk);
    act = ((m_ctrl & 16) != 0) ? (m_left > 0) : ((m_flags & e) != 0);
    if ((m_ctrl & 32) != 0) begin exp_en = bk ? 0 : 1; exp_val = (!bk && act) ? 1 : 0; end
    else begin exp_en = act ? 1 : 0; exp_val = 0; end
    case (bus_addr)
      0: exp_rd = m_flags;
      1: exp_rd = m_ctrl;
      2, 3, 4, 5: exp_rd = m_alm[bus_addr - 2];
      default: exp_rd = 0;
    endcase
    chk("model R7/R10/R11 pin", {irq_drv_en, irq_val}, exp_en * 2 + exp_val);
    chk("model R12 rdata", bus_rdata, exp_rd);
  end

  // ---------------- stimulus ----------------
  task automatic tk(); @(posedge clk); #8; endtask

  task automatic idle();
    bus_sel = 0; bus_wr = 0; sec_tick = 0; wdt_expire = 0; pwr_fail = 0;
  endtask

  task automatic wr(input int a, input int d);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
    tk(); idle();
  endtask

  task automatic rd(input int a, output int d);
    bus_sel = 1; bus_wr = 0; bus_addr = 3'(a);
    #1 d = bus_rdata;
    tk(); idle();
  endtask

  task automatic tick_at(input int s, input int m);
    now_sec = 7'(s); now_min = 7'(m); sec_tick = 1;
    tk(); sec_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d, cnt;
    repeat (3) tk();
    rst_n = 1;
    tk();
    // R1 reset state
    chk("R1 pin drive", irq_drv_en, 0);
    rd(1, d); chk("R1 ctrl", d, 'h14);
    rd(0, d); chk("R1 flags", d, 0);
    rd(4, d); chk("R1 hour alarm", d, 0);
    // R12 readback
    wr(2, 'h25); wr(3, 'h80); wr(4, 'h80); wr(5, 'hA3);
    rd(2, d); chk("R12 sec alarm", d, 'h25);
    rd(5, d); chk("R12 date alarm", d, 'hA3);
    rd(6, d); chk("R12 unused addr", d, 0);
    wr(5, 'h80);
    // R3 match without strobe does nothing
    now_sec = 7'h25; repeat (3) tk();
    rd(0, d); chk("R3 no strobe", d, 0);
    tick_at('h25, 0);
    rd(0, d); chk("R3 strobe match", d, 2);
    rd(0, d); chk("R5 cleared by read", d, 0);
    tick_at('h26, 0);
    rd(0, d); chk("R2 compared field mismatch", d, 0);
    wr(3, 'h14); tick_at('h25, 'h13);
    rd(0, d); chk("R2 minutes mismatch", d, 0);
    tick_at('h25, 'h14);
    rd(0, d); chk("R2 minutes match", d, 2);
    wr(2, 'h80); wr(3, 'h80); tick_at('h59, 'h33);
    rd(0, d); chk("R2 all ignored fires", d, 2);
    // R4 sources set flags regardless of enables
    wr(1, 0);
    wdt_expire = 1; tk(); idle();
    rd(0, d); chk("R4 watchdog flag", d, 1);
    pwr_fail = 1; tk(); idle();
    wdt_expire = 1; tk(); idle();
    // R5 write to flags ignored
    wr(0, 0);
    rd(0, d); chk("R5 write ignored", d, 5);
    // R6 event during read is kept
    wdt_expire = 1; tk(); idle();
    pwr_fail = 1; rd(0, d); chk("R6 read returns old", d, 1);
    rd(0, d); chk("R6 event kept", d, 4);
    // R7 level, active high
    wr(1, 'h22); tick_at(1, 1);
    chk("R7 level active", {irq_drv_en, irq_val}, 3);
    repeat (10) tk();
    chk("R7 level holds", {irq_drv_en, irq_val}, 3);
    rd(0, d);
    chk("R7 level released", {irq_drv_en, irq_val}, 2);
    // R10 open drain active low
    wr(1, 'h02);
    chk("R10 idle released", irq_drv_en, 0);
    tick_at(2, 1);
    chk("R10 driven low", {irq_drv_en, irq_val}, 2);
    rd(0, d);
    // R8 pulse length, no extension
    wr(1, 'h34);
    pwr_fail = 1; tk(); idle();
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      if (irq_val) cnt++;
      if (i == 2) pwr_fail = 1;
      tk(); pwr_fail = 0;
    end
    chk("R8 pulse cycles", cnt, P);
    rd(0, d);
    // R9 read cuts pulse
    pwr_fail = 1; tk(); idle();
    tk();
    chk("R9 pulse running", irq_val, 1);
    rd(0, d);
    chk("R9 pulse cut", {irq_drv_en, irq_val}, 2);
    // R11 backup behaviour
    on_backup = 1;
    wr(1, 'h22); tick_at(3, 1);
    chk("R11 active high released", irq_drv_en, 0);
    rd(0, d);
    wr(1, 'h02); tick_at(4, 1);
    chk("R11 no backup enable", irq_drv_en, 0);
    rd(0, d);
    wr(1, 'h0A); tick_at(5, 1);
    chk("R11 alarm in backup", {irq_drv_en, irq_val}, 2);
    rd(0, d);
    wr(1, 'h0D); pwr_fail = 1; tk(); idle();
    wdt_expire = 1; tk(); idle();
    chk("R11 pf and wdog suppressed", irq_drv_en, 0);
    rd(0, d); chk("R11 flags still set", d, 5);
    on_backup = 0;
    repeat (4) tk();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule